// File: doc/BRIEF.md
# Host Parallel Bus Slave Port

This block sits on the device side of a strobe-driven parallel bus owned by an external host controller. The host wiggles a command/data select, an active-low chip select, active-low write and read strobes and a data bus. The block samples all of them with the system clock through a synchronizer chain. A small state machine turns the strobe edges into four kinds of access: command write, status read, data write and data read. Inside one chip-select window the host may repeat strobes to move several bytes.

Toward the core the block offers a command register with a one-cycle valid pulse, a status byte input, a write-data stream with a valid/ready handshake and a read-data stream with a valid/ready handshake. A request input raises an interrupt line toward the host. The host answers it by polling the status register.

A static mode input selects byte transfers on data bits [7:0], or half-width transfers on bits [3:0] in which every byte takes two strobes, low nibble first. The data bus is split into an input, an output and an output enable. The pad ring ties them together.

The state machine has five states. ST_IDLE means no window is open. ST_ARMED means the window is open and the bus is not driven. ST_WRITE means a write strobe is low. ST_READ means a read strobe is low and the bus is driven. ST_HOLD means the window is open after a read and the bus is still driven. Its transitions are:
- open: ST_IDLE to ST_ARMED when chip select is seen low.
- wr-fall: ST_ARMED or ST_HOLD to ST_WRITE.
- rd-fall: ST_ARMED or ST_HOLD to ST_READ. Write wins if both strobes are low.
- wr-rise: ST_WRITE to ST_ARMED. The access is captured here.
- rd-rise: ST_READ to ST_HOLD.
- close: any state to ST_IDLE when chip select is seen high. Close takes priority over every other transition.

Top module: `pbus_slave`

## Requirements
- R1: After reset, cmd_q is 0x00 and cmd_valid, wr_valid, rd_ready, hb_data_oe and hb_irq are all low.
- R2: A completed write with select high loads cmd_q and gives exactly one single-cycle cmd_valid pulse. cmd_q never changes without that pulse.
- R3: A completed write with select low presents the byte on wr_data with wr_valid high, and holds both until a cycle with wr_ready high. A byte that completes while an earlier byte is still pending is discarded.
- R4: A read with select high drives the current status_i value on the data bus.
- R5: A read with select low and rd_valid high drives rd_data and consumes it with exactly one rd_ready cycle. With rd_valid low the read returns 0x00 and no rd_ready cycle occurs.
- R6: While chip select is high, strobes have no effect: no cmd_valid, no wr_valid, and no bus drive.
- R7: Several bytes can be written and read with repeated strobes inside one chip-select window.
- R8: With nib_mode high, each byte takes two strobes on data bits [3:0], low nibble first, in both directions. Output bits [7:4] read as zero.
- R9: Raising chip select resets the nibble phase, so a lone nibble is discarded and the next window starts with a low nibble.
- R10: hb_data_oe rises only after a read strobe and stays high until chip select rises. It is low during writes and outside windows.
- R11: An irq_req pulse sets hb_irq. hb_irq stays set through other accesses and clears when the host starts a status read.
- R12: Write data is taken as it stands when the write strobe rises, not when the strobe falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| nib_mode | input | 1 | 1 = two 4-bit strobes per byte, 0 = 8-bit strobes |
| hb_sel_cmd | input | 1 | 1 = command/status, 0 = data |
| hb_cs_n | input | 1 | Chip select, active low |
| hb_wr_n | input | 1 | Write strobe, active low |
| hb_rd_n | input | 1 | Read strobe, active low |
| hb_data_i | input | BYTE_W | Bus data from host |
| hb_data_o | output | BYTE_W | Bus data toward host |
| hb_data_oe | output | 1 | Bus output enable |
| hb_irq | output | 1 | Interrupt request to host |
| cmd_q | output | BYTE_W | Command register |
| cmd_valid | output | 1 | One-cycle pulse on a new command |
| status_i | input | BYTE_W | Status byte read by the host |
| irq_req | input | 1 | Core request, sets hb_irq |
| wr_data | output | BYTE_W | Byte written by the host |
| wr_valid | output | 1 | wr_data holds a pending byte |
| wr_ready | input | 1 | Core accepts wr_data |
| rd_data | input | BYTE_W | Byte offered to the host |
| rd_valid | input | 1 | rd_data is available |
| rd_ready | output | 1 | rd_data consumed this cycle |

## Verification
The bench builds the block with its default values: BYTE_W = 8 and SYNC_STAGES = 2. Byte width 8 makes both the full-byte and the split-nibble paths reachable from the same vectors. It also keeps the upper-half zeroing of nibble reads visible on the bus. Two synchronizer stages keep each strobe-to-event delay short. That lets a host phase of six clocks show every state-machine transition and every handshake outcome, including a second byte arriving while the first is still pending.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_WRITE,
        ST_READ,
        ST_HOLD
    } bus_state_t;

    typedef struct packed {
        logic sel;
        logic cs_n;
        logic wr_n;
        logic rd_n;
    } bus_ctl_t;

    localparam bus_ctl_t CTL_IDLE = '{sel: 1'b0, cs_n: 1'b1, wr_n: 1'b1, rd_n: 1'b1};

endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            logic [W-1:0] r;
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) r <= RST_VAL;
                    else        r <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) r <= RST_VAL;
                    else        r <= g_stage[g-1].r;
                end
            end
        end
    endgenerate

    assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/pbus_fsm.sv
module pbus_fsm
    import pbus_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  bus_ctl_t ctl,
    output logic     wr_done,
    output logic     rd_start,
    output logic     win_end,
    output logic     drive
);

    bus_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: close has priority, write beats read
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!ctl.cs_n) state_d = ST_ARMED;
            end
            ST_ARMED, ST_HOLD: begin
                if (ctl.cs_n)       state_d = ST_IDLE;
                else if (!ctl.wr_n) state_d = ST_WRITE;
                else if (!ctl.rd_n) state_d = ST_READ;
            end
            ST_WRITE: begin
                if (ctl.cs_n)      state_d = ST_IDLE;
                else if (ctl.wr_n) state_d = ST_ARMED;
            end
            ST_READ: begin
                if (ctl.cs_n)      state_d = ST_IDLE;
                else if (ctl.rd_n) state_d = ST_HOLD;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_done  = 1'b0;
        rd_start = 1'b0;
        win_end  = 1'b0;
        drive    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ARMED: begin
                rd_start = (state_d == ST_READ);
                win_end  = (state_d == ST_IDLE);
            end
            ST_WRITE: begin
                wr_done = (state_d == ST_ARMED);
                win_end = (state_d == ST_IDLE);
            end
            ST_READ: begin
                drive   = 1'b1;
                win_end = (state_d == ST_IDLE);
            end
            ST_HOLD: begin
                drive    = 1'b1;
                rd_start = (state_d == ST_READ);
                win_end  = (state_d == ST_IDLE);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pbus_regs.sv
module pbus_regs #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nib_mode,
    input  logic              s_sel,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              wr_done,
    input  logic              rd_start,
    input  logic              win_end,
    output logic [BYTE_W-1:0] cmd_q,
    output logic              cmd_valid,
    input  logic [BYTE_W-1:0] status_i,
    input  logic              irq_req,
    output logic              irq,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic              rd_valid,
    output logic              rd_ready,
    output logic [BYTE_W-1:0] out_q
);

    localparam int NIB_W = BYTE_W / 2;

    logic              phase_q;
    logic [NIB_W-1:0]  lo_q;
    logic [BYTE_W-1:0] snap_q;
    logic [BYTE_W-1:0] wr_byte;
    logic [BYTE_W-1:0] rd_src;
    logic              first_strobe;
    logic              byte_done;
    logic              stat_read;
    logic              accept;

    assign first_strobe = !nib_mode || !phase_q;
    assign byte_done    = wr_done && (!nib_mode || phase_q);
    assign stat_read    = rd_start && first_strobe && s_sel;
    assign accept       = !wr_valid || wr_ready;
    assign rd_ready     = rd_start && first_strobe && !s_sel && rd_valid;

    always_comb begin
        wr_byte = nib_mode ? {s_data[NIB_W-1:0], lo_q} : s_data;
        if (s_sel)         rd_src = status_i;
        else if (rd_valid) rd_src = rd_data;
        else               rd_src = '0;
    end

    // nibble phase, cleared when the window closes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            lo_q    <= '0;
        end else if (win_end) begin
            phase_q <= 1'b0;
        end else if (nib_mode && (wr_done || rd_start)) begin
            phase_q <= !phase_q;
            if (wr_done && !phase_q) lo_q <= s_data[NIB_W-1:0];
        end
    end

    // command register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            cmd_valid <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            if (byte_done && s_sel) begin
                cmd_q     <= wr_byte;
                cmd_valid <= 1'b1;
            end
        end
    end

    // write stream, one-deep
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_data  <= '0;
            wr_valid <= 1'b0;
        end else if (byte_done && !s_sel && accept) begin
            wr_data  <= wr_byte;
            wr_valid <= 1'b1;
        end else if (wr_valid && wr_ready) begin
            wr_valid <= 1'b0;
        end
    end

    // read output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            snap_q <= '0;
        end else if (rd_start) begin
            if (first_strobe) begin
                snap_q <= rd_src;
                out_q  <= nib_mode ? {{NIB_W{1'b0}}, rd_src[NIB_W-1:0]} : rd_src;
            end else begin
                out_q  <= {{NIB_W{1'b0}}, snap_q[BYTE_W-1:NIB_W]};
            end
        end
    end

    // interrupt: set wins over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         irq <= 1'b0;
        else if (irq_req)   irq <= 1'b1;
        else if (stat_read) irq <= 1'b0;
    end

endmodule

// File: rtl/pbus_slave.sv
module pbus_slave
    import pbus_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nib_mode,
    input  logic              hb_sel_cmd,
    input  logic              hb_cs_n,
    input  logic              hb_wr_n,
    input  logic              hb_rd_n,
    input  logic [BYTE_W-1:0] hb_data_i,
    output logic [BYTE_W-1:0] hb_data_o,
    output logic              hb_data_oe,
    output logic              hb_irq,
    output logic [BYTE_W-1:0] cmd_q,
    output logic              cmd_valid,
    input  logic [BYTE_W-1:0] status_i,
    input  logic              irq_req,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic              rd_valid,
    output logic              rd_ready
);

    localparam int SYNC_W = $bits(bus_ctl_t) + BYTE_W;

    bus_ctl_t          raw_ctl;
    bus_ctl_t          s_ctl;
    logic [BYTE_W-1:0] s_data;
    logic              wr_done;
    logic              rd_start;
    logic              win_end;

    assign raw_ctl = '{sel: hb_sel_cmd, cs_n: hb_cs_n, wr_n: hb_wr_n, rd_n: hb_rd_n};

    pbus_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({CTL_IDLE, {BYTE_W{1'b0}}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({raw_ctl, hb_data_i}),
        .q     ({s_ctl, s_data})
    );

    pbus_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (s_ctl),
        .wr_done  (wr_done),
        .rd_start (rd_start),
        .win_end  (win_end),
        .drive    (hb_data_oe)
    );

    pbus_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .nib_mode  (nib_mode),
        .s_sel     (s_ctl.sel),
        .s_data    (s_data),
        .wr_done   (wr_done),
        .rd_start  (rd_start),
        .win_end   (win_end),
        .cmd_q     (cmd_q),
        .cmd_valid (cmd_valid),
        .status_i  (status_i),
        .irq_req   (irq_req),
        .irq       (hb_irq),
        .wr_data   (wr_data),
        .wr_valid  (wr_valid),
        .wr_ready  (wr_ready),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .rd_ready  (rd_ready),
        .out_q     (hb_data_o)
    );

endmodule

// File: rtl/pbus_slave_chk.sv
module pbus_slave_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hb_cs_n,
    input logic              hb_data_oe,
    input logic              hb_irq,
    input logic              irq_req,
    input logic [BYTE_W-1:0] cmd_q,
    input logic              cmd_valid,
    input logic [BYTE_W-1:0] wr_data,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic              rd_valid,
    input logic              rd_ready
);

    a_r2_cmd_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    a_r2_cmd_moves_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_q) |-> cmd_valid);

    a_r3_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)));

    a_r5_pop_only_when_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> rd_valid);

    a_r10_drive_inside_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hb_data_oe) |-> !$past(hb_cs_n));

    a_r11_irq_from_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hb_irq) |-> $past(irq_req));

    a_r11_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hb_irq) |-> hb_data_oe);

endmodule

bind pbus_slave pbus_slave_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hb_cs_n    (hb_cs_n),
    .hb_data_oe (hb_data_oe),
    .hb_irq     (hb_irq),
    .irq_req    (irq_req),
    .cmd_q      (cmd_q),
    .cmd_valid  (cmd_valid),
    .wr_data    (wr_data),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready)
);

// File: tb/pbus_slave_bench.sv
`timescale 1ns/1ps
module pbus_slave_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nib_mode = 1'b0;
    logic       hb_sel_cmd = 1'b0;
    logic       hb_cs_n = 1'b1;
    logic       hb_wr_n = 1'b1;
    logic       hb_rd_n = 1'b1;
    logic [7:0] hb_data_i = 8'h00;
    logic [7:0] hb_data_o;
    logic       hb_data_oe;
    logic       hb_irq;
    logic [7:0] cmd_q;
    logic       cmd_valid;
    logic [7:0] status_i = 8'h00;
    logic       irq_req = 1'b0;
    logic [7:0] wr_data;
    logic       wr_valid;
    logic       wr_ready = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic       rd_valid = 1'b0;
    logic       rd_ready;

    int errors = 0;
    int checks = 0;
    int cmd_pulses = 0;
    int pops = 0;

    always #10 clk = ~clk;

    pbus_slave u_pbus_slave (
        .clk(clk), .rst_n(rst_n), .nib_mode(nib_mode), .hb_sel_cmd(hb_sel_cmd),
        .hb_cs_n(hb_cs_n), .hb_wr_n(hb_wr_n), .hb_rd_n(hb_rd_n),
        .hb_data_i(hb_data_i), .hb_data_o(hb_data_o), .hb_data_oe(hb_data_oe),
        .hb_irq(hb_irq), .cmd_q(cmd_q), .cmd_valid(cmd_valid), .status_i(status_i),
        .irq_req(irq_req), .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready)
    );

    always @(posedge clk) begin
        if (cmd_valid) cmd_pulses <= cmd_pulses + 1;
        if (rd_ready && rd_valid) pops <= pops + 1;
    end

    // mode(1) kind(2: 0 cmd write, 1 data write, 2 status read, 3 data read) value(8) expect(8)
    localparam logic [18:0] VEC [8] = '{
        {1'b0, 2'd0, 8'hC3, 8'hC3},
        {1'b0, 2'd1, 8'h5E, 8'h5E},
        {1'b0, 2'd2, 8'h96, 8'h96},
        {1'b0, 2'd3, 8'h3C, 8'h3C},
        {1'b1, 2'd0, 8'h7B, 8'h7B},
        {1'b1, 2'd1, 8'hE1, 8'hE1},
        {1'b1, 2'd2, 8'h4D, 8'h4D},
        {1'b1, 2'd3, 8'hB8, 8'hB8}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cs_on();
        hb_cs_n = 1'b0;
        tick(4);
    endtask

    task automatic cs_off();
        hb_cs_n = 1'b1;
        tick(6);
    endtask

    task automatic strobe_wr(input logic s, input logic [7:0] d);
        hb_sel_cmd = s;
        hb_data_i  = d;
        tick(3);
        hb_wr_n = 1'b0;
        tick(6);
        hb_wr_n = 1'b1;
        tick(6);
    endtask

    task automatic strobe_rd(input logic s, output logic [7:0] v);
        hb_sel_cmd = s;
        tick(3);
        hb_rd_n = 1'b0;
        tick(6);
        v = hb_data_o;
        hb_rd_n = 1'b1;
        tick(6);
    endtask

    task automatic host_wr(input logic s, input logic [7:0] d);
        if (nib_mode) begin
            strobe_wr(s, {4'h0, d[3:0]});
            strobe_wr(s, {4'h0, d[7:4]});
        end else begin
            strobe_wr(s, d);
        end
    endtask

    task automatic host_rd(input logic s, output logic [7:0] v);
        logic [7:0] lo, hi;
        if (nib_mode) begin
            strobe_rd(s, lo);
            strobe_rd(s, hi);
            v = {hi[3:0], lo[3:0]};
            chk("R8 upper bits zero", {hi[7:4], lo[7:4]}, 0);
        end else begin
            strobe_rd(s, v);
        end
    endtask

    task automatic ready_pulse();
        wr_ready = 1'b1;
        tick(1);
        wr_ready = 1'b0;
        tick(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [18:0] v;
        logic [7:0]  got;
        int          c0, p0;

        tick(3);
        // R1 reset state
        chk("R1 cmd_q", cmd_q, 0);
        chk("R1 flags", {cmd_valid, wr_valid, rd_ready, hb_data_oe, hb_irq}, 0);
        rst_n = 1'b1;
        tick(4);

        // vector walk: R2 R3 R4 R5 R8
        for (int i = 0; i < 8; i++) begin
            v = VEC[i];
            nib_mode = v[18];
            c0 = cmd_pulses;
            p0 = pops;
            cs_on();
            case (v[17:16])
                2'd0: begin
                    host_wr(1'b1, v[15:8]);
                    chk("R2/R8 cmd_q", cmd_q, v[7:0]);
                    chk("R2 one cmd pulse", cmd_pulses - c0, 1);
                end
                2'd1: begin
                    host_wr(1'b0, v[15:8]);
                    chk("R3/R8 wr_data", wr_data, v[7:0]);
                    chk("R3 wr_valid", wr_valid, 1);
                    ready_pulse();
                    chk("R3 drained", wr_valid, 0);
                end
                2'd2: begin
                    status_i = v[15:8];
                    host_rd(1'b1, got);
                    chk("R4/R8 status", got, v[7:0]);
                end
                default: begin
                    rd_data = v[15:8];
                    rd_valid = 1'b1;
                    host_rd(1'b0, got);
                    rd_valid = 1'b0;
                    chk("R5/R8 read data", got, v[7:0]);
                    chk("R5 one pop", pops - p0, 1);
                end
            endcase
            cs_off();
        end
        nib_mode = 1'b0;

        // R6 strobes with chip select high
        c0 = cmd_pulses;
        strobe_wr(1'b1, 8'h5A);
        strobe_wr(1'b0, 8'h5B);
        chk("R6 no cmd pulse", cmd_pulses - c0, 0);
        chk("R6 cmd_q kept", cmd_q, 8'h7B);
        chk("R6 no wr_valid", wr_valid, 0);
        hb_rd_n = 1'b0;
        tick(6);
        chk("R6 no drive", hb_data_oe, 0);
        hb_rd_n = 1'b1;
        tick(4);

        // R7 R10 R3 multiple bytes, drive window, overflow
        cs_on();
        strobe_wr(1'b0, 8'h11);
        chk("R7 first byte", wr_data, 8'h11);
        chk("R10 no drive on write", hb_data_oe, 0);
        ready_pulse();
        strobe_wr(1'b0, 8'h22);
        chk("R7 second byte", wr_data, 8'h22);
        strobe_wr(1'b0, 8'h44);
        chk("R3 overflow discarded", wr_data, 8'h22);
        ready_pulse();
        chk("R3 slot empty", wr_valid, 0);
        rd_valid = 1'b1;
        rd_data = 8'hA1;
        strobe_rd(1'b0, got);
        chk("R7 read one", got, 8'hA1);
        chk("R10 drive held after strobe", hb_data_oe, 1);
        rd_data = 8'hA2;
        strobe_rd(1'b0, got);
        chk("R7 read two", got, 8'hA2);
        rd_valid = 1'b0;
        cs_off();
        chk("R10 drive released", hb_data_oe, 0);

        // R5 empty read
        p0 = pops;
        cs_on();
        rd_data = 8'hEE;
        strobe_rd(1'b0, got);
        chk("R5 empty read value", got, 8'h00);
        chk("R5 no pop", pops - p0, 0);
        cs_off();

        // R9 lone nibble discarded
        nib_mode = 1'b1;
        cs_on();
        strobe_wr(1'b0, 8'h0F);
        cs_off();
        chk("R9 no byte from lone nibble", wr_valid, 0);
        cs_on();
        strobe_wr(1'b0, 8'h07);
        strobe_wr(1'b0, 8'h08);
        cs_off();
        chk("R9 fresh pair", wr_data, 8'h87);
        ready_pulse();
        nib_mode = 1'b0;

        // R12 data taken at rising edge
        cs_on();
        hb_sel_cmd = 1'b0;
        hb_data_i = 8'h12;
        tick(3);
        hb_wr_n = 1'b0;
        tick(3);
        hb_data_i = 8'h34;
        tick(3);
        hb_wr_n = 1'b1;
        tick(6);
        chk("R12 late data", wr_data, 8'h34);
        ready_pulse();
        cs_off();

        // R11 interrupt
        irq_req = 1'b1;
        tick(1);
        irq_req = 1'b0;
        tick(2);
        chk("R11 set", hb_irq, 1);
        cs_on();
        host_wr(1'b0, 8'h55);
        ready_pulse();
        chk("R11 held through data write", hb_irq, 1);
        status_i = 8'h81;
        strobe_rd(1'b1, got);
        chk("R11 cleared by status read", hb_irq, 0);
        chk("R4 status with irq", got, 8'h81);
        cs_off();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule